// File: doc/BRIEF.md
# Address Error Exception Sequencer

This block sits beside a CPU core and watches every bus access made by the CPU or by a DMA master. Each access comes with the master type, whether it is a word or a byte access, the lowest address bit, the operating mode, and a region decode that says whether the target is external memory or a prohibited area. An access that breaks the rules for its master sets a pending address-error flag.

The exception entry does not start at once. It waits until the faulting bus cycle has ended and the current instruction has completed. Then it saves the CPU context onto a downward-growing stack through a 16-bit write port. Next it issues a vector fetch for the address-error slot, takes the handler address when the read returns, and hands the new PC, status values and stack pointer back to the core.

While the sequence runs, any further address error is dropped. This stops the register saves from triggering another exception entry, even when the stack pointer is odd.

Top module: `addr_err_seq`

## Requirements
- R1: A CPU word access (`acc_word`=1) with `acc_addr_lsb`=1 raises an address error. A CPU word access with an even address, or a CPU byte access at any address, does not.
- R2: A CPU access with `acc_ext`=1 while `single_chip`=1 raises an address error. The same access with `single_chip`=0 does not.
- R3: An access with `acc_prohib`=1 raises an address error whatever the master (`acc_master` 0 = CPU, 1 = DMA).
- R4: A DMA access (`acc_master`=1) to external space is normal. A DMA access to non-external space raises an error. An odd word address is not an error for DMA.
- R5: A raised error sets `error_pending` on the next clock edge. Entry starts (`busy` rises) on the edge after both `cycle_done` and `insn_done` have been seen, each at or after the fault cycle. Until then `busy` stays 0.
- R6: Entry performs four `stk_we` writes on consecutive cycles. The addresses are SP-2, SP-4, SP-6 and SP-8. The data words are, in order: PC[31:16], PC[15:0], {8'h00,CCR}, {8'h00,EXR}.
- R7: `vector_fetch` pulses for exactly one cycle, in the cycle after the last write. During that pulse `vector_addr` equals the parameter VEC_ADDR (default 'h24). The sequencer then waits for `vec_valid`, which may come in the strobe cycle or any later cycle.
- R8: `pc_load` pulses for one cycle, in the cycle after `vec_valid` is accepted. During that pulse: `pc_out` is the returned data, `ccr_out` is the saved CCR with bit 7 set, `exr_out` is the saved EXR with bit 7 cleared, and `sp_out` is SP-8.
- R9: An address error raised while `busy`=1 is not accepted. After the sequence ends, `error_pending` stays 0 and no second entry starts.
- R10: `int_mask` is 1 exactly while `busy` is 1. `busy` and `error_pending` are both 0 in the cycle after `pc_load`.
- R11: With an odd SP, the sequence still runs to `pc_load` with the same cycle count, and `sp_out` = SP-8.
- R12: After synchronous reset (`rst_n`=0), `error_pending`, `busy`, `stk_we`, `vector_fetch` and `pc_load` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_master | input | 1 | Master type: 0 = CPU, 1 = DMA |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_addr_lsb | input | 1 | Address bit 0 of the access |
| single_chip | input | 1 | Operating mode: 1 = single-chip |
| acc_ext | input | 1 | Target lies in external memory space |
| acc_prohib | input | 1 | Target lies in the prohibited region |
| cycle_done | input | 1 | The current bus cycle completes |
| insn_done | input | 1 | The current instruction completes |
| cpu_pc | input | PC_W | PC to save |
| cpu_ccr | input | 8 | CCR to save |
| cpu_exr | input | 8 | EXR to save |
| cpu_sp | input | AW | Stack pointer at entry |
| vec_valid | input | 1 | Vector read data is valid |
| vec_data | input | PC_W | Handler address read from the vector slot |
| error_pending | output | 1 | An address error is awaiting or under service |
| busy | output | 1 | Entry sequence in progress |
| int_mask | output | 1 | Interrupt mask forced during entry |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | AW | Stack write address |
| stk_wdata | output | 16 | Stack write data |
| vector_fetch | output | 1 | One-cycle vector read request |
| vector_addr | output | AW | Vector slot address |
| pc_load | output | 1 | Load new context into the core |
| pc_out | output | PC_W | New PC |
| ccr_out | output | 8 | New CCR |
| exr_out | output | 8 | New EXR |
| sp_out | output | AW | New stack pointer |

## Verification
Timing, counting from the edge that samples the fault with both completion inputs high:
- `error_pending` is visible after 1 edge.
- `busy` and the first stack write appear after 2 edges.
- The next three writes follow on the next three edges.
- `vector_fetch` appears on edge 6.
- `pc_load` appears one edge after `vec_valid` is sampled.
- `busy` drops one edge after that.

Each test task drives inputs on the falling edge and steps falling edge by falling edge. At every step it compares the outputs against the cycle in this schedule, so a result that comes early or late fails. The classification tests read `error_pending` one edge after the access, holding both completion inputs low so that no entry can start during the test.

// File: rtl/addr_err_pkg.sv
// Package: shared types and constants for the address error sequencer.
// Assumes 16-bit stack words and 8-bit status registers.
package addr_err_pkg;
    localparam int WORD_W = 16;
    localparam int STAT_W = 8;

    typedef enum logic {
        MST_CPU = 1'b0,
        MST_DMA = 1'b1
    } master_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH  = 3'd1,
        ST_VEC   = 3'd2,
        ST_WAITV = 3'd3,
        ST_LOAD  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/addr_err_check.sv
// Module: addr_err_check
// Purely combinational rule table that decides if one access is an address error.
// Assumes the region decode inputs are already valid in the access cycle.
module addr_err_check
    import addr_err_pkg::*;
(
    input  logic    master,
    input  logic    is_word,
    input  logic    addr_lsb,
    input  logic    single_chip,
    input  logic    in_ext,
    input  logic    in_prohib,
    output logic    err
);
    logic cpu_err;
    logic dma_err;

    // Rules per master; the prohibited region faults for everyone.
    always_comb begin
        cpu_err = (is_word && addr_lsb) || (in_ext && single_chip);
        dma_err = !in_ext;
        err     = in_prohib || ((master == MST_CPU) ? cpu_err : dma_err);
    end
endmodule

// File: rtl/addr_err_gate.sv
// Module: addr_err_gate
// Holds the pending flag and tracks completion of the faulting bus cycle and
// instruction. Errors are accepted only while the entry sequence is idle.
// Assumes 'done' pulses once at the end of each entry sequence.
module addr_err_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic err,
    input  logic busy,
    input  logic cycle_done,
    input  logic insn_done,
    input  logic done,
    output logic pending,
    output logic start
);
    logic bus_ok;
    logic ins_ok;

    // Capture a new fault and accumulate the two completion conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            bus_ok  <= 1'b0;
            ins_ok  <= 1'b0;
        end else if (done) begin
            pending <= 1'b0;
            bus_ok  <= 1'b0;
            ins_ok  <= 1'b0;
        end else if (!busy) begin
            if (acc_valid && err && !pending) begin
                pending <= 1'b1;
                bus_ok  <= cycle_done;
                ins_ok  <= insn_done;
            end else if (pending) begin
                bus_ok  <= bus_ok | cycle_done;
                ins_ok  <= ins_ok | insn_done;
            end
        end
    end

    // Entry may begin once both completions have been recorded.
    always_comb start = pending && bus_ok && ins_ok && !busy;

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !pending);

    // R9
    no_new_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && (busy || !(acc_valid && err))) |=> !pending);
endmodule

// File: rtl/addr_err_entry.sv
// Module: addr_err_entry
// Exception entry state machine: pushes PC, CCR, EXR as 16-bit words with
// pre-decrement, fetches the handler vector and presents the new context.
// Assumes the stack write port accepts one write per cycle and PC_W is a
// multiple of 16.
module addr_err_entry
    import addr_err_pkg::*;
#(
    parameter int             AW        = 32,
    parameter int             PC_W      = 32,
    parameter logic [AW-1:0]  VEC_ADDR  = 'h24,
    parameter int             MASK_BIT  = 7,
    parameter int             TRACE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PC_W-1:0]   cpu_pc,
    input  logic [STAT_W-1:0] cpu_ccr,
    input  logic [STAT_W-1:0] cpu_exr,
    input  logic [AW-1:0]     cpu_sp,
    input  logic              vec_valid,
    input  logic [PC_W-1:0]   vec_data,
    output logic              busy,
    output logic              stk_we,
    output logic [AW-1:0]     stk_addr,
    output logic [WORD_W-1:0] stk_wdata,
    output logic              vector_fetch,
    output logic [AW-1:0]     vector_addr,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_out,
    output logic [STAT_W-1:0] ccr_out,
    output logic [STAT_W-1:0] exr_out,
    output logic [AW-1:0]     sp_out
);
    localparam int PC_WORDS   = PC_W / WORD_W;
    localparam int PUSH_WORDS = PC_WORDS + 2;
    localparam int IDX_W      = $clog2(PUSH_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PUSH_WORDS - 1);
    localparam logic [AW-1:0] STEP = AW'(WORD_W / 8);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [PC_W-1:0]   pc_r;
    logic [STAT_W-1:0] ccr_r;
    logic [STAT_W-1:0] exr_r;
    logic [AW-1:0]     sp_r;
    logic [PC_W-1:0]   vec_r;
    logic [WORD_W-1:0] words [PUSH_WORDS];

    // Slice the saved PC into stack words, most significant first.
    for (genvar g = 0; g < PC_WORDS; g++) begin : g_pc_word
        assign words[g] = pc_r[PC_W-1-g*WORD_W -: WORD_W];
    end
    assign words[PC_WORDS]     = {{(WORD_W-STAT_W){1'b0}}, ccr_r};
    assign words[PC_WORDS + 1] = {{(WORD_W-STAT_W){1'b0}}, exr_r};

    // Sequence control, context capture and stack pointer walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            pc_r  <= '0;
            ccr_r <= '0;
            exr_r <= '0;
            sp_r  <= '0;
            vec_r <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    pc_r  <= cpu_pc;
                    ccr_r <= cpu_ccr;
                    exr_r <= cpu_exr;
                    sp_r  <= cpu_sp - STEP;
                    idx   <= '0;
                    state <= ST_PUSH;
                end
                ST_PUSH: begin
                    if (idx == LAST_IDX) begin
                        state <= ST_VEC;
                    end else begin
                        idx  <= idx + 1'b1;
                        sp_r <= sp_r - STEP;
                    end
                end
                ST_VEC, ST_WAITV: begin
                    if (vec_valid) begin
                        vec_r <= vec_data;
                        state <= ST_LOAD;
                    end else begin
                        state <= ST_WAITV;
                    end
                end
                ST_LOAD: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state and captured context.
    always_comb begin
        busy         = (state != ST_IDLE);
        stk_we       = (state == ST_PUSH);
        stk_addr     = sp_r;
        stk_wdata    = words[idx];
        vector_fetch = (state == ST_VEC);
        vector_addr  = VEC_ADDR;
        pc_load      = (state == ST_LOAD);
        pc_out       = vec_r;
        ccr_out      = ccr_r | STAT_W'(1 << MASK_BIT);
        exr_out      = exr_r & ~STAT_W'(1 << TRACE_BIT);
        sp_out       = sp_r;
    end

    // R6
    stk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - STEP));

    // R7
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vector_fetch |=> !vector_fetch);

    // R7
    fetch_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vector_fetch) |-> $past(stk_we));

    // R10
    load_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);
endmodule

// File: rtl/addr_err_seq.sv
// Module: addr_err_seq (top)
// Classifies bus accesses, latches address errors, and runs the CPU exception
// entry once the faulting bus cycle and instruction are complete. Errors seen
// during entry are dropped. Assumes one access sample per cycle.
module addr_err_seq
    import addr_err_pkg::*;
#(
    parameter int             AW        = 32,
    parameter int             PC_W      = 32,
    parameter logic [AW-1:0]  VEC_ADDR  = 'h24,
    parameter int             MASK_BIT  = 7,
    parameter int             TRACE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_master,
    input  logic              acc_word,
    input  logic              acc_addr_lsb,
    input  logic              single_chip,
    input  logic              acc_ext,
    input  logic              acc_prohib,
    input  logic              cycle_done,
    input  logic              insn_done,
    input  logic [PC_W-1:0]   cpu_pc,
    input  logic [7:0]        cpu_ccr,
    input  logic [7:0]        cpu_exr,
    input  logic [AW-1:0]     cpu_sp,
    input  logic              vec_valid,
    input  logic [PC_W-1:0]   vec_data,
    output logic              error_pending,
    output logic              busy,
    output logic              int_mask,
    output logic              stk_we,
    output logic [AW-1:0]     stk_addr,
    output logic [15:0]       stk_wdata,
    output logic              vector_fetch,
    output logic [AW-1:0]     vector_addr,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_out,
    output logic [7:0]        ccr_out,
    output logic [7:0]        exr_out,
    output logic [AW-1:0]     sp_out
);
    logic err;
    logic start;

    addr_err_check u_check (
        .master      (acc_master),
        .is_word     (acc_word),
        .addr_lsb    (acc_addr_lsb),
        .single_chip (single_chip),
        .in_ext      (acc_ext),
        .in_prohib   (acc_prohib),
        .err         (err)
    );

    addr_err_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .err        (err),
        .busy       (busy),
        .cycle_done (cycle_done),
        .insn_done  (insn_done),
        .done       (pc_load),
        .pending    (error_pending),
        .start      (start)
    );

    addr_err_entry #(
        .AW        (AW),
        .PC_W      (PC_W),
        .VEC_ADDR  (VEC_ADDR),
        .MASK_BIT  (MASK_BIT),
        .TRACE_BIT (TRACE_BIT)
    ) u_entry (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cpu_pc       (cpu_pc),
        .cpu_ccr      (cpu_ccr),
        .cpu_exr      (cpu_exr),
        .cpu_sp       (cpu_sp),
        .vec_valid    (vec_valid),
        .vec_data     (vec_data),
        .busy         (busy),
        .stk_we       (stk_we),
        .stk_addr     (stk_addr),
        .stk_wdata    (stk_wdata),
        .vector_fetch (vector_fetch),
        .vector_addr  (vector_addr),
        .pc_load      (pc_load),
        .pc_out       (pc_out),
        .ccr_out      (ccr_out),
        .exr_out      (exr_out),
        .sp_out       (sp_out)
    );

    // Interrupt mask is forced for the whole entry sequence.
    always_comb int_mask = busy;

    // R5
    start_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(error_pending));
endmodule

// File: tb/addr_err_seq_tb.sv
module addr_err_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_master = 0, acc_word = 0, acc_addr_lsb = 0;
    logic        single_chip = 0, acc_ext = 0, acc_prohib = 0;
    logic        cycle_done = 0, insn_done = 0;
    logic [31:0] cpu_pc = '0;
    logic [7:0]  cpu_ccr = '0, cpu_exr = '0;
    logic [31:0] cpu_sp = '0;
    logic        vec_valid = 0;
    logic [31:0] vec_data = '0;
    logic        error_pending, busy, int_mask, stk_we, vector_fetch, pc_load;
    logic [31:0] stk_addr, vector_addr, pc_out, sp_out;
    logic [15:0] stk_wdata;
    logic [7:0]  ccr_out, exr_out;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    addr_err_seq u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_master(acc_master),
        .acc_word(acc_word), .acc_addr_lsb(acc_addr_lsb), .single_chip(single_chip),
        .acc_ext(acc_ext), .acc_prohib(acc_prohib), .cycle_done(cycle_done),
        .insn_done(insn_done), .cpu_pc(cpu_pc), .cpu_ccr(cpu_ccr), .cpu_exr(cpu_exr),
        .cpu_sp(cpu_sp), .vec_valid(vec_valid), .vec_data(vec_data),
        .error_pending(error_pending), .busy(busy), .int_mask(int_mask),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .vector_fetch(vector_fetch), .vector_addr(vector_addr), .pc_load(pc_load),
        .pc_out(pc_out), .ccr_out(ccr_out), .exr_out(exr_out), .sp_out(sp_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 0; cycle_done = 0; insn_done = 0; vec_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one access for one cycle at a falling edge.
    task automatic present(input logic m, input logic w, input logic lsb, input logic sc,
                           input logic ext, input logic pro, input logic cd, input logic id);
        acc_valid = 1; acc_master = m; acc_word = w; acc_addr_lsb = lsb;
        single_chip = sc; acc_ext = ext; acc_prohib = pro;
        cycle_done = cd; insn_done = id;
        @(negedge clk);
        acc_valid = 0; cycle_done = 0; insn_done = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 pending", error_pending, 0);
        chk("R12 busy", busy, 0);
        chk("R12 stk_we", stk_we, 0);
        chk("R12 vector_fetch", vector_fetch, 0);
        chk("R12 pc_load", pc_load, 0);
    endtask

    task automatic t_classify(input string req, input logic m, input logic w, input logic lsb,
                              input logic sc, input logic ext, input logic pro, input logic exp);
        do_reset();
        present(m, w, lsb, sc, ext, pro, 0, 0);
        chk(req, error_pending, exp);
        chk({req, " no start"}, busy, 0);
    endtask

    // Walks the sequence from the first push cycle to idle.
    task automatic run_entry(input string req, input logic [31:0] sp, input logic [31:0] pc,
                             input logic [7:0] ccr, input logic [7:0] exr,
                             input logic [31:0] vec, input int vdelay, input bit inject);
        logic [15:0] exp_w [4];
        exp_w[0] = pc[31:16]; exp_w[1] = pc[15:0];
        exp_w[2] = {8'h00, ccr}; exp_w[3] = {8'h00, exr};
        for (int k = 0; k < 4; k++) begin
            chk({req, " R6 we"}, stk_we, 1);
            chk({req, " R6 addr"}, stk_addr, sp - 32'(2 * (k + 1)));
            chk({req, " R6 data"}, stk_wdata, exp_w[k]);
            chk({req, " R10 mask"}, int_mask, 1);
            if (inject && k == 1) begin
                acc_valid = 1; acc_master = 0; acc_word = 1; acc_addr_lsb = 1;
                acc_prohib = 1; cycle_done = 1; insn_done = 1;
            end
            @(negedge clk);
            acc_valid = 0; acc_prohib = 0; cycle_done = 0; insn_done = 0;
        end
        chk({req, " R7 fetch"}, vector_fetch, 1);
        chk({req, " R7 vaddr"}, vector_addr, 32'h24);
        chk({req, " R7 no write"}, stk_we, 0);
        for (int d = 0; d < vdelay; d++) begin
            @(negedge clk);
            chk({req, " R7 fetch single"}, vector_fetch, 0);
            chk({req, " R7 wait busy"}, busy, 1);
        end
        vec_valid = 1; vec_data = vec;
        @(negedge clk);
        vec_valid = 0; vec_data = '0;
        chk({req, " R8 load"}, pc_load, 1);
        chk({req, " R8 pc"}, pc_out, vec);
        chk({req, " R8 ccr"}, ccr_out, ccr | 8'h80);
        chk({req, " R8 exr"}, exr_out, exr & 8'h7F);
        chk({req, " R8 sp"}, sp_out, sp - 32'd8);
        @(negedge clk);
        chk({req, " R10 idle"}, busy, 0);
        chk({req, " R10 pend clr"}, error_pending, 0);
        chk({req, " R10 mask off"}, int_mask, 0);
    endtask

    task automatic t_full(input string req, input logic [31:0] sp, input logic [31:0] pc,
                          input logic [7:0] ccr, input logic [7:0] exr,
                          input logic [31:0] vec, input int vdelay, input bit inject);
        do_reset();
        cpu_sp = sp; cpu_pc = pc; cpu_ccr = ccr; cpu_exr = exr;
        present(0, 1, 1, 0, 0, 0, 1, 1);
        chk({req, " R5 pending"}, error_pending, 1);
        chk({req, " R5 not yet"}, busy, 0);
        @(negedge clk);
        chk({req, " R5 started"}, busy, 1);
        run_entry(req, sp, pc, ccr, exr, vec, vdelay, inject);
        if (inject) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R9 no re-entry", busy, 0);
                chk("R9 no pending", error_pending, 0);
            end
        end
    endtask

    // R5: entry waits for both completion signals.
    task automatic t_wait();
        do_reset();
        cpu_sp = 32'h2000; cpu_pc = 32'h0001_2344; cpu_ccr = 8'h05; cpu_exr = 8'h81;
        present(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 pending dma", error_pending, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5 waits", busy, 0);
        end
        cycle_done = 1;
        @(negedge clk);
        cycle_done = 0;
        chk("R5 bus only", busy, 0);
        @(negedge clk);
        chk("R5 bus only later", busy, 0);
        insn_done = 1;
        @(negedge clk);
        insn_done = 0;
        chk("R5 flags edge", busy, 0);
        @(negedge clk);
        chk("R5 start", busy, 1);
        run_entry("R5", 32'h2000, 32'h0001_2344, 8'h05, 8'h81, 32'h0000_8000, 0, 0);
    endtask

    initial begin
        t_reset();
        t_classify("R1 cpu odd word", 0, 1, 1, 0, 0, 0, 1);
        t_classify("R1 cpu even word", 0, 1, 0, 0, 0, 0, 0);
        t_classify("R1 cpu odd byte", 0, 0, 1, 0, 0, 0, 0);
        t_classify("R2 cpu ext single-chip", 0, 0, 0, 1, 1, 0, 1);
        t_classify("R2 cpu ext expanded", 0, 0, 0, 0, 1, 0, 0);
        t_classify("R3 cpu prohibited", 0, 0, 0, 0, 0, 1, 1);
        t_classify("R3 dma prohibited", 1, 0, 0, 0, 1, 1, 1);
        t_classify("R4 dma ext", 1, 1, 1, 0, 1, 0, 0);
        t_classify("R4 dma internal", 1, 0, 0, 0, 0, 0, 1);
        t_full("R6", 32'h0000_1000, 32'hDEAD_BEEF, 8'h12, 8'h80, 32'h0000_4000, 0, 0);
        t_full("R7 wait", 32'h0000_3000, 32'h1234_5678, 8'h7F, 8'hFF, 32'h0000_ABCC, 3, 0);
        t_full("R9", 32'h0000_1800, 32'h0000_0100, 8'h00, 8'h07, 32'h0000_0200, 1, 1);
        t_full("R11 odd sp", 32'h0000_1001, 32'hCAFE_0002, 8'h80, 8'h80, 32'h0000_0600, 0, 0);
        t_wait();
        ended = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule